// File: doc/BRIEF.md
# Status Register and Write-Permit Unit

This block sits beside the SPI command engine of a serial nonvolatile memory. It keeps the 8-bit status byte and decides, every cycle, whether the engine may commit a status update and whether a given array address may be written. The engine passes in single-cycle strobes that it has already decoded: set-latch, clear-latch, status-write with its data byte, and end-of-write-command (chip-select rising after a status or array write). The board-level write-protect pin comes in directly, active low.

The write-enable latch must be set before any write-type command. It drops when the write-type command ends, whether or not the write went through. A lock bit in the status byte, combined with the protect pin held low, freezes the status byte. A two-bit protect field fences off an upper part of the array. Nonvolatile retention is modelled by ordinary registers cleared by the power-up reset. All ports are plain control and status signals. No data stream crosses the edge, so there is no handshake and no back-pressure.

Top module: `srwp_unit`

## Requirements
- R1: After power-up reset the status byte reads 0x00, and both permits are 0.
- R2: The status byte is {lock-enable (bit 7), three spare bits (6:4), protect field (3:2), write-enable latch (bit 1), 0 (bit 0)}. The spare bits store and read back whatever was last written.
- R3: A set-latch strobe makes bit 1 read 1 from the next cycle. A clear-latch strobe makes it read 0 from the next cycle.
- R4: An end-of-write strobe clears the latch. A clear-latch or end-of-write strobe wins over a set-latch strobe in the same cycle.
- R5: A status-write strobe while the status permit is 1 stores data bits 7:2 from the next cycle. Data bits 1:0 have no effect, and the latch stays set until the end-of-write strobe.
- R6: A status-write strobe while the latch is 0 leaves the status byte unchanged.
- R7: The status permit is the latch AND NOT (lock-enable AND protect pin low). When lock-enable is 1 and the pin is low, a status-write strobe is ignored. With the pin high it is accepted.
- R8: The array-write permit is 0 whenever the latch is 0.
- R9: With the latch set, the array permit for address A is 0 inside the protected region and 1 outside it. The protect field selects the region: 00 none, 01 0x6000–0x7FFF, 10 0x4000–0x7FFF, 11 the whole array.
- R10: The protect pin has no effect on the array permit. While lock-enable is 0 it has no effect on the status permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| set_wel_i | input | 1 | Set-latch command strobe |
| clr_wel_i | input | 1 | Clear-latch command strobe |
| sr_wr_i | input | 1 | Status-write strobe |
| sr_data_i | input | 8 | Status-write data byte |
| wr_end_i | input | 1 | Write-type command ended (chip-select rose) |
| wp_n_i | input | 1 | Protect pin, active low |
| arr_addr_i | input | ADDR_W | Array address under test |
| status_o | output | 8 | Status byte for reads |
| sr_wr_ok_o | output | 1 | Status write permitted |
| arr_wr_ok_o | output | 1 | Array write to arr_addr_i permitted |

## Verification
The hardest state to reach is a locked status byte. To write lock-enable, the latch must be set, the pin must be high and a status write must land. Only then can the pin be dropped to test that a later status write is refused. The stimulus sets the latch, writes 0xFF with the pin high, ends the command, and sets the latch again. It then lowers the pin, attempts a write, and reads the byte back. The region boundaries are probed on both sides of each edge, with the field in each of its four values.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_e;

  typedef struct packed {
    logic       lock_en;
    logic [2:0] spare;
    prot_e      prot;
  } sr_fields_t;

  localparam int unsigned SR_W = 8;
endpackage

// File: rtl/srwp_wel.sv
module srwp_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic end_i,
  output logic wel_o
);
  logic drop;
  assign drop = clr_i | end_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (drop)  wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end

  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !end_i) |=> wel_o);
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || end_i) |=> !wel_o);
endmodule

// File: rtl/srwp_fields.sv
module srwp_fields
  import srwp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             ok_i,
  input  logic [SR_W-1:0]  data_i,
  output sr_fields_t       fields_o
);
  sr_fields_t nxt;
  assign nxt = '{lock_en: data_i[7], spare: data_i[6:4], prot: prot_e'(data_i[3:2])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fields_o <= '{lock_en: 1'b0, spare: 3'b000, prot: PROT_NONE};
    else if (wr_i && ok_i) fields_o <= nxt;
  end

  a_r6_r7_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !ok_i) |=> $stable(fields_o));
  a_r5_accepted_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ok_i) |=> (fields_o.spare == $past(data_i[6:4])));
endmodule

// File: rtl/srwp_range.sv
module srwp_range
  import srwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  prot_e             prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TOP = ADDR_W - 1;
  logic [1:0] hi;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign hi = addr_i[TOP -: 2];
    end else begin : g_narrow
      assign hi = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    unique case (prot_i)
      PROT_NONE:    hit_o = 1'b0;
      PROT_QUARTER: hit_o = (hi == 2'b11);
      PROT_HALF:    hit_o = hi[1];
      default:      hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
  import srwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wr_end_i,
  input  logic              wp_n_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic [7:0]        status_o,
  output logic              sr_wr_ok_o,
  output logic              arr_wr_ok_o
);
  logic       wel;
  logic       locked;
  logic       in_prot;
  sr_fields_t fld;

  srwp_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_wel_i),
    .clr_i (clr_wel_i),
    .end_i (wr_end_i),
    .wel_o (wel)
  );

  srwp_fields u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (sr_wr_i),
    .ok_i     (sr_wr_ok_o),
    .data_i   (sr_data_i),
    .fields_o (fld)
  );

  srwp_range #(.ADDR_W(ADDR_W)) u_range (
    .prot_i (fld.prot),
    .addr_i (arr_addr_i),
    .hit_o  (in_prot)
  );

  assign locked      = fld.lock_en & ~wp_n_i;
  assign sr_wr_ok_o  = wel & ~locked;
  assign arr_wr_ok_o = wel & ~in_prot;
  assign status_o    = {fld.lock_en, fld.spare, fld.prot, wel, 1'b0};

  a_r8_no_latch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |-> (!arr_wr_ok_o && !sr_wr_ok_o));
  a_r9_open_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b00 && status_o[1]) |-> arr_wr_ok_o);
  a_r9_closed_when_all: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);
  a_r5_low_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && (|sr_data_i[1:0]) && !status_o[1] && !set_wel_i) |=> !status_o[1]);
  a_r7_locked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] && !wp_n_i) |-> !sr_wr_ok_o);
endmodule

// File: tb/srwp_unit_tb_top.sv
module srwp_unit_tb_top;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_wel = 1'b0, clr_wel = 1'b0, sr_wr = 1'b0, wr_end = 1'b0;
  logic [7:0]    sr_data = 8'h00;
  logic          wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          sr_ok, arr_ok;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  srwp_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
    .sr_wr_i(sr_wr), .sr_data_i(sr_data), .wr_end_i(wr_end), .wp_n_i(wp_n),
    .arr_addr_i(addr), .status_o(status), .sr_wr_ok_o(sr_ok), .arr_wr_ok_o(arr_ok)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.kind)
          0: act = int'(status);
          1: act = int'(sr_ok);
          default: act = int'(arr_ok);
        endcase
        checks++;
        if (act != it.exp) begin
          failures++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    #1;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
    #1;
  endtask

  task automatic expect_arr(input int a, input int exp, input string tag);
    addr = AW'(a);
    expect_v(2, exp, tag);
  endtask

  // kinds: 0 set, 1 clear, 2 status write, 3 end, 4 set+end, 5 set+clear
  task automatic strobe(input int op, input logic [7:0] d);
    @(negedge clk);
    set_wel = (op == 0 || op == 4 || op == 5);
    clr_wel = (op == 1 || op == 5);
    sr_wr   = (op == 2);
    wr_end  = (op == 3 || op == 4);
    sr_data = d;
    @(negedge clk);
    set_wel = 1'b0; clr_wel = 1'b0; sr_wr = 1'b0; wr_end = 1'b0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_v(0, 8'h00, "R1 status after reset");
    expect_v(1, 0, "R1 status permit after reset");
    expect_arr(0, 0, "R1 array permit after reset");

    strobe(0, 8'h00);
    expect_v(0, 8'h02, "R3 latch set");
    strobe(2, 8'hFF);
    expect_v(0, 8'hFE, "R5 write stores 7:2, latch kept");
    strobe(3, 8'h00);
    expect_v(0, 8'hFC, "R4 end clears latch");
    expect_arr(0, 0, "R8 no latch no array write");

    strobe(0, 8'h00);
    expect_arr(0, 0, "R9 field 11 protects address 0");
    wp_n = 1'b0;
    expect_v(1, 0, "R7 locked permit");
    strobe(2, 8'h00);
    expect_v(0, 8'hFE, "R7 locked write ignored");
    wp_n = 1'b1;
    expect_v(1, 1, "R7 pin high permits");
    strobe(2, 8'h04);
    expect_v(0, 8'h06, "R5 write field 01");
    expect_arr(16'h5FFF, 1, "R9 quarter below edge");
    expect_arr(16'h6000, 0, "R9 quarter at edge");
    expect_arr(16'h7FFF, 0, "R9 quarter top");
    strobe(2, 8'h08);
    expect_v(0, 8'h0A, "R5 write field 10");
    expect_arr(16'h3FFF, 1, "R9 half below edge");
    expect_arr(16'h4000, 0, "R9 half at edge");
    strobe(2, 8'h00);
    expect_arr(16'h7FFF, 1, "R9 field 00 top open");
    wp_n = 1'b0;
    expect_v(1, 1, "R10 pin low, lock off, status permit");
    expect_arr(16'h7FFF, 1, "R10 pin low, array permit");
    wp_n = 1'b1;

    strobe(1, 8'h00);
    expect_v(0, 8'h00, "R3 clear strobe");
    expect_v(1, 0, "R8 status permit with latch 0");
    strobe(0, 8'h00);
    strobe(2, 8'h70);
    expect_v(0, 8'h72, "R2 spare bits read back");
    strobe(3, 8'h00);
    expect_v(0, 8'h70, "R2 spare kept after end");
    strobe(2, 8'h8F);
    expect_v(0, 8'h70, "R6 write without latch ignored");
    strobe(4, 8'h00);
    expect_v(0, 8'h70, "R4 end beats set");
    strobe(5, 8'h00);
    expect_v(0, 8'h70, "R4 clear beats set");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule